// File: doc/BRIEF.md
# Integer ALU for a Three-Operand Register Machine

This block is the integer arithmetic and logic unit of a simple load-store processor pipeline. Every cycle it takes two 32-bit register operands, a 16-bit immediate with a select that swaps it in for the second operand, a 5-bit constant shift count with a select that swaps in a register-supplied count, and a 4-bit operation code. It returns a 32-bit result, a zero flag and a signed-overflow flag.

The unit covers addition and subtraction in trapping and non-trapping forms, four bitwise functions, three shifts, two less-than comparisons and a load-upper-immediate path. Operand preparation, including the extension of the immediate, happens inside the block, so the surrounding pipeline only routes raw fields. By default the outputs are registered, which gives one cycle of latency; a parameter removes the register.

Top module: `lsalu_top`

## Requirements
- R1: Codes 0 (add) and 1 (add, no trap) return A+B modulo 2^32; codes 2 (subtract) and 3 (subtract, no trap) return A-B modulo 2^32.
- R2: The overflow flag is 1 only for codes 0 and 2 when the exact two's-complement result falls outside the signed 32-bit range; for every other code it is 0.
- R3: Code 4 returns A AND B, code 5 A OR B, code 6 A XOR B and code 7 the complement of A OR B.
- R4: With the immediate select at 1, the second operand is the 16-bit immediate: zero-extended for codes 4 to 7, sign-extended for all other codes.
- R5: With the shift-source select at 0 the shift count is the 5-bit constant input; at 1 it is bits 4:0 of operand A, and bits 31:5 of A have no effect.
- R6: Code 8 shifts the second operand left, code 9 shifts it right with zero fill and code 10 shifts it right with copies of bit 31 filling the vacated positions.
- R7: Code 11 returns 1 when A is below B in two's-complement order and code 12 returns 1 when A is below B as unsigned numbers; otherwise both return 0.
- R8: Code 13 returns the 16-bit immediate in bits 31:16 with bits 15:0 cleared.
- R9: The zero flag is 1 exactly when the 32-bit result is 0.
- R10: The outputs appear one clock after the inputs; during reset the result and the overflow flag are 0 and the zero flag is 1.
- R11: Codes 14 and 15 return 0 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 32 | First register operand, also the variable shift count source |
| opB | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| useImm | input | 1 | 1 selects the extended immediate as the second operand |
| shamtConst | input | 5 | Constant shift count |
| shiftVar | input | 1 | 1 takes the shift count from operand A |
| opCode | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zeroFlag | output | 1 | Result equals zero |
| ovfFlag | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
The block holds no state beyond its output register, so a wrong decode or a wrong operand select shows up in the very next cycle as a bad result or flag for that one operation. The vectors therefore target the points where a wrong choice is visible: signed limits for overflow, operands that differ in sign for the two comparisons, immediates with bit 15 set for the extension rule, and shift counts hidden in the low bits of a large operand.

// File: rtl/lsalu_pkg.sv
package lsalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10,
    OP_SLT  = 4'd11,
    OP_SLTU = 4'd12,
    OP_LUI  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } aluOpE;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_SUM   = 3'd1,
    SEL_LOGIC = 3'd2,
    SEL_SHIFT = 3'd3,
    SEL_LESS  = 3'd4,
    SEL_UPPER = 3'd5
  } resSelE;

  typedef struct packed {
    resSelE     resSel;
    logic       subEn;
    logic       ovfEn;
    logic       zeroExt;
    logic [1:0] logicFn;  // 0 and, 1 or, 2 xor, 3 nor
    logic [1:0] shiftFn;  // 0 left, 1 right zero fill, 2 right sign fill
    logic       lessUns;
  } aluStrbT;

endpackage

// File: rtl/lsalu_ctrl.sv
module lsalu_ctrl
  import lsalu_pkg::*;
(
  input  logic [3:0] opCode,
  output aluStrbT    strb
);

  aluOpE opDec;
  assign opDec = aluOpE'(opCode);

  always_comb begin
    strb         = '0;
    strb.resSel  = SEL_NONE;
    case (opDec)
      OP_ADD:  begin strb.resSel = SEL_SUM; strb.ovfEn = 1'b1; end
      OP_ADDU: strb.resSel = SEL_SUM;
      OP_SUB:  begin strb.resSel = SEL_SUM; strb.subEn = 1'b1; strb.ovfEn = 1'b1; end
      OP_SUBU: begin strb.resSel = SEL_SUM; strb.subEn = 1'b1; end
      OP_AND:  begin strb.resSel = SEL_LOGIC; strb.zeroExt = 1'b1; strb.logicFn = 2'd0; end
      OP_OR:   begin strb.resSel = SEL_LOGIC; strb.zeroExt = 1'b1; strb.logicFn = 2'd1; end
      OP_XOR:  begin strb.resSel = SEL_LOGIC; strb.zeroExt = 1'b1; strb.logicFn = 2'd2; end
      OP_NOR:  begin strb.resSel = SEL_LOGIC; strb.zeroExt = 1'b1; strb.logicFn = 2'd3; end
      OP_SLL:  begin strb.resSel = SEL_SHIFT; strb.shiftFn = 2'd0; end
      OP_SRL:  begin strb.resSel = SEL_SHIFT; strb.shiftFn = 2'd1; end
      OP_SRA:  begin strb.resSel = SEL_SHIFT; strb.shiftFn = 2'd2; end
      OP_SLT:  begin strb.resSel = SEL_LESS; strb.subEn = 1'b1; end
      OP_SLTU: begin strb.resSel = SEL_LESS; strb.subEn = 1'b1; strb.lessUns = 1'b1; end
      OP_LUI:  strb.resSel = SEL_UPPER;
      default: strb.resSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/lsalu_datapath.sv
module lsalu_datapath
  import lsalu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int IMM_W   = 16,
  parameter bit OUT_REG = 1'b1,
  localparam int SH_W   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [IMM_W-1:0] imm,
  input  logic             useImm,
  input  logic [SH_W-1:0]  shamtConst,
  input  logic             shiftVar,
  input  aluStrbT          strb,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovfFlag
);

  localparam int EXT_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] immExt, bSel, bAdd, sum;
  logic             carry, ovfRaw, lessSigned, lessBit;
  logic [SH_W-1:0]  shAmt;
  logic [WIDTH-1:0] shiftRes, logicRes, resNext;
  logic             zeroNext, ovfNext;

  // operand selection and immediate extension
  assign immExt = strb.zeroExt ? {{EXT_W{1'b0}}, imm} : {{EXT_W{imm[IMM_W-1]}}, imm};
  assign bSel   = useImm ? immExt : opB;

  // shared adder, also used by both comparisons
  assign bAdd          = strb.subEn ? ~bSel : bSel;
  assign {carry, sum}  = {1'b0, opA} + {1'b0, bAdd} + {{WIDTH{1'b0}}, strb.subEn};
  assign ovfRaw        = (opA[WIDTH-1] == bAdd[WIDTH-1]) && (sum[WIDTH-1] != opA[WIDTH-1]);
  assign lessSigned    = (opA[WIDTH-1] != bSel[WIDTH-1]) ? opA[WIDTH-1] : sum[WIDTH-1];
  assign lessBit       = strb.lessUns ? ~carry : lessSigned;

  // shifter
  assign shAmt = shiftVar ? opA[SH_W-1:0] : shamtConst;
  always_comb begin
    case (strb.shiftFn)
      2'd0:    shiftRes = bSel << shAmt;
      2'd1:    shiftRes = bSel >> shAmt;
      default: shiftRes = $unsigned($signed(bSel) >>> shAmt);
    endcase
  end

  // bitwise unit
  always_comb begin
    case (strb.logicFn)
      2'd0:    logicRes = opA & bSel;
      2'd1:    logicRes = opA | bSel;
      2'd2:    logicRes = opA ^ bSel;
      default: logicRes = ~(opA | bSel);
    endcase
  end

  // result mux
  always_comb begin
    case (strb.resSel)
      SEL_SUM:   resNext = sum;
      SEL_LOGIC: resNext = logicRes;
      SEL_SHIFT: resNext = shiftRes;
      SEL_LESS:  resNext = {{(WIDTH-1){1'b0}}, lessBit};
      SEL_UPPER: resNext = {imm, {EXT_W{1'b0}}};
      default:   resNext = '0;
    endcase
  end

  assign zeroNext = (resNext == '0);
  assign ovfNext  = strb.ovfEn & ovfRaw;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          result   <= '0;
          zeroFlag <= 1'b1;
          ovfFlag  <= 1'b0;
        end else begin
          result   <= resNext;
          zeroFlag <= zeroNext;
          ovfFlag  <= ovfNext;
        end
      end
    end else begin : g_comb
      assign result   = resNext;
      assign zeroFlag = zeroNext;
      assign ovfFlag  = ovfNext;
    end
  endgenerate

endmodule

// File: rtl/lsalu_top.sv
module lsalu_top
  import lsalu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [15:0] imm,
  input  logic        useImm,
  input  logic [4:0]  shamtConst,
  input  logic        shiftVar,
  input  logic [3:0]  opCode,
  output logic [31:0] result,
  output logic        zeroFlag,
  output logic        ovfFlag
);

  aluStrbT strb;

  lsalu_ctrl u_ctrl (
    .opCode (opCode),
    .strb   (strb)
  );

  lsalu_datapath #(
    .WIDTH   (32),
    .IMM_W   (16),
    .OUT_REG (OUT_REG)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .opA        (opA),
    .opB        (opB),
    .imm        (imm),
    .useImm     (useImm),
    .shamtConst (shamtConst),
    .shiftVar   (shiftVar),
    .strb       (strb),
    .result     (result),
    .zeroFlag   (zeroFlag),
    .ovfFlag    (ovfFlag)
  );

  generate
    if (OUT_REG) begin : g_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
        (opCode != 4'd0 && opCode != 4'd2) |=> !ovfFlag); // R2
      AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
        zeroFlag == (result == 32'd0)); // R9
      AST_LESS_BINARY: assert property (@(posedge clk) disable iff (!rstN)
        (opCode == 4'd11 || opCode == 4'd12) |=> (result[31:1] == 31'd0)); // R7
      AST_UPPER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        (opCode == 4'd13) |=> (result == {$past(imm), 16'h0000})); // R8
      AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        (opCode == 4'd14 || opCode == 4'd15) |=> (zeroFlag && !ovfFlag)); // R11
    end
  endgenerate

endmodule

// File: tb/lsalu_top_tb_top.sv
`timescale 1ns/1ps
module lsalu_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [15:0] imm = '0;
  logic        useImm = 1'b0;
  logic [4:0]  shamtConst = '0;
  logic        shiftVar = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] result;
  logic        zeroFlag, ovfFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lsalu_top dut_i (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .imm(imm), .useImm(useImm),
    .shamtConst(shamtConst), .shiftVar(shiftVar), .opCode(opCode),
    .result(result), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  // behavioural reference
  function automatic logic [32:0] refModel(int op, logic [31:0] a, logic [31:0] b,
                                           logic [15:0] im, bit ui, logic [4:0] sc, bit sv);
    logic [31:0] bb, r;
    int          amt;
    longint      exact;
    bit          ov = 1'b0;
    if (ui) bb = (op >= 4 && op <= 7) ? {16'h0, im} : {{16{im[15]}}, im};
    else    bb = b;
    amt = sv ? int'(a % 32) : int'(sc);
    r = 32'd0;
    case (op)
      0, 1: r = a + bb;
      2, 3: r = a - bb;
      4: r = a & bb;
      5: r = a | bb;
      6: r = a ^ bb;
      7: r = ~(a | bb);
      8: r = bb << amt;
      9: r = bb >> amt;
      10: r = $unsigned($signed(bb) >>> amt);
      11: r = ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
      12: r = (a < bb) ? 32'd1 : 32'd0;
      13: r = {im, 16'h0};
      default: r = 32'd0;
    endcase
    if (op == 0) exact = longint'($signed(a)) + longint'($signed(bb));
    else         exact = longint'($signed(a)) - longint'($signed(bb));
    if ((op == 0 || op == 2) && (exact > 64'sd2147483647 || exact < -64'sd2147483648)) ov = 1'b1;
    return {ov, r};
  endfunction

  task automatic runVec(string req, int op, logic [31:0] a, logic [31:0] b,
                        logic [15:0] im, bit ui, logic [4:0] sc, bit sv);
    logic [32:0] exp;
    bit          expZ;
    @(negedge clk);
    opCode = 4'(op); opA = a; opB = b; imm = im; useImm = ui; shamtConst = sc; shiftVar = sv;
    exp  = refModel(op, a, b, im, ui, sc, sv);
    expZ = (exp[31:0] == 32'd0);
    @(negedge clk);
    checks++;
    if (result !== exp[31:0] || zeroFlag !== expZ || ovfFlag !== exp[32]) begin
      fails++;
      $display("FAIL %s op=%0d: got res=%h z=%b v=%b, expected res=%h z=%b v=%b",
               req, op, result, zeroFlag, ovfFlag, exp[31:0], expZ, exp[32]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (result !== 32'd0 || zeroFlag !== 1'b1 || ovfFlag !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: got res=%h z=%b v=%b, expected 0 1 0", result, zeroFlag, ovfFlag);
    end
    rstN = 1'b1;
    // R1 / R2 arithmetic
    runVec("R1", 0, 32'd100, 32'd23, 16'h0, 0, 5'd0, 0);
    runVec("R2", 0, 32'h7fffffff, 32'd1, 16'h0, 0, 5'd0, 0);
    runVec("R2", 1, 32'h7fffffff, 32'd1, 16'h0, 0, 5'd0, 0);
    runVec("R2", 2, 32'h80000000, 32'd1, 16'h0, 0, 5'd0, 0);
    runVec("R2", 3, 32'h80000000, 32'd1, 16'h0, 0, 5'd0, 0);
    runVec("R1", 3, 32'd5, 32'd9, 16'h0, 0, 5'd0, 0);
    runVec("R9", 0, 32'hffffffff, 32'd1, 16'h0, 0, 5'd0, 0);
    runVec("R2", 0, 32'h80000000, 32'h80000000, 16'h0, 0, 5'd0, 0);
    // R3 bitwise
    runVec("R3", 4, 32'hf0f0aaaa, 32'h0ff05555, 16'h0, 0, 5'd0, 0);
    runVec("R3", 5, 32'hf0f0aaaa, 32'h0ff05555, 16'h0, 0, 5'd0, 0);
    runVec("R3", 6, 32'hf0f0aaaa, 32'h0ff0aaaa, 16'h0, 0, 5'd0, 0);
    runVec("R3", 7, 32'h0, 32'h0, 16'h0, 0, 5'd0, 0);
    runVec("R3", 7, 32'hffff0000, 32'h0000ffff, 16'h0, 0, 5'd0, 0);
    // R4 immediate extension
    runVec("R4", 0, 32'd10, 32'hdeadbeef, 16'hffff, 1, 5'd0, 0);
    runVec("R4", 4, 32'hffffffff, 32'hdeadbeef, 16'hffff, 1, 5'd0, 0);
    runVec("R4", 5, 32'h12340000, 32'h0, 16'h8001, 1, 5'd0, 0);
    runVec("R4", 11, 32'd0, 32'd5, 16'hfffe, 1, 5'd0, 0);
    // R5 / R6 shifts
    runVec("R6", 8, 32'h0, 32'h80000001, 16'h0, 0, 5'd4, 0);
    runVec("R6", 9, 32'h0, 32'h80000000, 16'h0, 0, 5'd31, 0);
    runVec("R6", 10, 32'h0, 32'h80000000, 16'h0, 0, 5'd31, 0);
    runVec("R6", 10, 32'h0, 32'h40000000, 16'h0, 0, 5'd8, 0);
    runVec("R5", 9, 32'hffffffe4, 32'hf0000000, 16'h0, 0, 5'd1, 1);
    runVec("R5", 8, 32'h00000020, 32'h0000abcd, 16'h0, 0, 5'd9, 1);
    runVec("R5", 10, 32'h1234567f, 32'h80000000, 16'h0, 0, 5'd0, 1);
    // R7 comparisons
    runVec("R7", 11, 32'hffffffff, 32'd1, 16'h0, 0, 5'd0, 0);
    runVec("R7", 12, 32'hffffffff, 32'd1, 16'h0, 0, 5'd0, 0);
    runVec("R7", 11, 32'h7fffffff, 32'h80000000, 16'h0, 0, 5'd0, 0);
    runVec("R7", 12, 32'h7fffffff, 32'h80000000, 16'h0, 0, 5'd0, 0);
    runVec("R7", 11, 32'd7, 32'd7, 16'h0, 0, 5'd0, 0);
    // R8 upper immediate
    runVec("R8", 13, 32'hffffffff, 32'hffffffff, 16'habcd, 0, 5'd0, 0);
    runVec("R8", 13, 32'h1, 32'h1, 16'h0000, 1, 5'd0, 0);
    // R11 reserved codes
    runVec("R11", 14, 32'h7fffffff, 32'd1, 16'h0, 0, 5'd0, 0);
    runVec("R11", 15, 32'h12345678, 32'h9abcdef0, 16'h1234, 1, 5'd3, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule